// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block is the issue stage of an in-order, statically scheduled dual-issue pipeline. It holds the two oldest decoded instructions in two slots. Each cycle it decides whether none, only the older, or both of them leave for execution. The decision rests on two things: the functional unit and register format that each instruction class needs, and read-after-write hazards. A hazard is either a source register whose load result is still outstanding, or the younger instruction reading the register that the older one writes. Program order is strict. The younger slot never issues ahead of the older one. When only the older one leaves, the younger one becomes the oldest and blocks any new pair until it has issued itself.

Pairs arrive from the fetch buffer over a valid/ready handshake. A pair transfers on a clock edge where both `pair_valid` and `pair_ready` are high. `pair_ready` is high only when the downstream stall is low and every occupied slot issues in the current cycle, so a new pair can be accepted in the same cycle the last held instruction leaves. The fetch buffer may hold `pair_valid` and the pair fields steady for any number of cycles while `pair_ready` is low. A pair always carries two instructions; an odd instruction is padded with a no-op. The load scoreboard and the stall input are plain level signals.

Top module: `dual_issue_pairer`

## Requirements
- R1: Class codes are 3 bits: 0 integer op, 1 float op, 2 integer load, 3 integer store, 4 float load, 5 float store, 6 branch, 7 no-op. Codes 0, 2, 3 and 6 are integer format; codes 1, 4 and 5 are float format. A no-op needs no functional unit and pairs with any class.
- R2: An integer op in the older slot and a float op in the younger slot, with no register conflict, both issue in the same cycle (`iss_cnt` = 2).
- R3: Two instructions that need the same unit cannot pair, and only the older one issues. The cases are two integer ops, two float ops, any two loads or stores, and two branches.
- R4: A load or store pairs with an operate, except a store together with an operate of the other format.
- R5: A branch pairs with a load, a float store or an operate, but not with an integer store.
- R6: An instruction cannot issue while `load_busy` is set for a source it reads. Operates and stores read sources A and B, loads and branches read only A, and a no-op reads nothing. A busy bit on a source the class does not read has no effect.
- R7: If the older slot cannot issue, the younger slot does not issue either (`iss_cnt` = 0).
- R8: If the younger instruction reads the destination of the older one, only the older one issues. Operates and loads write their destination; stores, branches and no-ops write none.
- R9: After a partial issue, the held instruction is the oldest. `pair_ready` stays low until it issues, and a new pair is accepted in the cycle it issues.
- R10: While `stall` is high, `iss_cnt` is 0, `pair_ready` is 0, and the slots keep their contents.
- R11: After reset, the slots are empty, `iss_cnt` is 0 and `pair_ready` is 1.
- R12: `pair_ready` is 1 exactly when `stall` is low and `iss_cnt` equals the number of occupied slots. A pair presented while `pair_ready` is low is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_valid | input | 1 | Fetch buffer offers a pair |
| pair_ready | output | 1 | Stage accepts the offered pair this cycle |
| old_cls | input | 3 | Class code of the older instruction |
| old_dst | input | RW | Destination register of the older instruction |
| old_sra | input | RW | Source A of the older instruction |
| old_srb | input | RW | Source B of the older instruction |
| yng_cls | input | 3 | Class code of the younger instruction |
| yng_dst | input | RW | Destination register of the younger instruction |
| yng_sra | input | RW | Source A of the younger instruction |
| yng_srb | input | RW | Source B of the younger instruction |
| load_busy | input | NREG | One bit per register, set while a load to it is in flight |
| stall | input | 1 | Downstream stall; freezes the stage |
| iss_cnt | output | 2 | Number of instructions issued this cycle (0, 1 or 2) |

## Verification
The bench goes after the legality exceptions: store with an operate of the other format, branch with an integer store, and a store placed in either slot. A design that keyed pairing on units alone would dual-issue those pairs and show `iss_cnt` 2 where 1 is due. It also checks that a held younger instruction keeps blocking refill while its own scoreboard bit stays set, and that the new pair enters in the very cycle it leaves. A design that refilled early would lose the held instruction, and one that refilled late would show a bubble. Further cases are busy bits on sources a class does not read, branches that carry a destination field, and a pair offered during a stall. Wrong decoding of read or write enables, or a stall that still lets a pair in, would show up as a wrong count or a wrong ready level.

// File: rtl/dip_pkg.sv
package dip_pkg;

  typedef enum logic [2:0] {
    CL_IOP = 3'd0,
    CL_FOP = 3'd1,
    CL_ILD = 3'd2,
    CL_IST = 3'd3,
    CL_FLD = 3'd4,
    CL_FST = 3'd5,
    CL_BR  = 3'd6,
    CL_NOP = 3'd7
  } iclass_e;

  typedef enum logic [2:0] {
    FU_NONE = 3'd0,
    FU_INT  = 3'd1,
    FU_FP   = 3'd2,
    FU_MEM  = 3'd3,
    FU_BR   = 3'd4
  } fu_e;

  function automatic fu_e fu_of(iclass_e c);
    case (c)
      CL_IOP:                         return FU_INT;
      CL_FOP:                         return FU_FP;
      CL_ILD, CL_IST, CL_FLD, CL_FST: return FU_MEM;
      CL_BR:                          return FU_BR;
      default:                        return FU_NONE;
    endcase
  endfunction

  function automatic logic is_fp_fmt(iclass_e c);
    return (c == CL_FOP) || (c == CL_FLD) || (c == CL_FST);
  endfunction

  function automatic logic is_store(iclass_e c);
    return (c == CL_IST) || (c == CL_FST);
  endfunction

  function automatic logic is_operate(iclass_e c);
    return (c == CL_IOP) || (c == CL_FOP);
  endfunction

  function automatic logic writes_dst(iclass_e c);
    return is_operate(c) || (c == CL_ILD) || (c == CL_FLD);
  endfunction

  function automatic logic reads_a(iclass_e c);
    return (c != CL_NOP);
  endfunction

  function automatic logic reads_b(iclass_e c);
    return is_operate(c) || is_store(c);
  endfunction

endpackage

// File: rtl/dip_pair_rules.sv
module dip_pair_rules
  import dip_pkg::*;
(
  input  iclass_e cls_a,
  input  iclass_e cls_b,
  output logic    pair_ok
);
  fu_e  fu_a, fu_b;
  logic unit_clash, st_op_clash, br_st_clash;

  always_comb begin
    fu_a        = fu_of(cls_a);
    fu_b        = fu_of(cls_b);
    unit_clash  = (fu_a == fu_b) && (fu_a != FU_NONE);
    st_op_clash = (is_store(cls_a) && is_operate(cls_b) &&
                   (is_fp_fmt(cls_a) != is_fp_fmt(cls_b))) ||
                  (is_store(cls_b) && is_operate(cls_a) &&
                   (is_fp_fmt(cls_b) != is_fp_fmt(cls_a)));
    br_st_clash = ((cls_a == CL_BR) && (cls_b == CL_IST)) ||
                  ((cls_b == CL_BR) && (cls_a == CL_IST));
    pair_ok     = !unit_clash && !st_op_clash && !br_st_clash;
  end

  // R3: identical non-nop classes never pair
  always_comb begin
    if ((cls_a == cls_b) && (cls_a != CL_NOP))
      assert_same_unit_R3: assert (!pair_ok);
  end

endmodule

// File: rtl/dip_src_hazard.sv
module dip_src_hazard
  import dip_pkg::*;
#(
  parameter int NREG = 32,
  parameter int RW   = 5
) (
  input  iclass_e           cls,
  input  logic [RW-1:0]     sra,
  input  logic [RW-1:0]     srb,
  input  logic [NREG-1:0]   busy,
  output logic              blocked
);
  logic hit_a, hit_b;

  always_comb begin
    hit_a   = reads_a(cls) && busy[sra];
    hit_b   = reads_b(cls) && busy[srb];
    blocked = hit_a || hit_b;
  end

endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
  import dip_pkg::*;
#(
  parameter  int NREG = 32,
  localparam int RW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pair_valid,
  output logic            pair_ready,
  input  logic [2:0]      old_cls,
  input  logic [RW-1:0]   old_dst,
  input  logic [RW-1:0]   old_sra,
  input  logic [RW-1:0]   old_srb,
  input  logic [2:0]      yng_cls,
  input  logic [RW-1:0]   yng_dst,
  input  logic [RW-1:0]   yng_sra,
  input  logic [RW-1:0]   yng_srb,
  input  logic [NREG-1:0] load_busy,
  input  logic            stall,
  output logic [1:0]      iss_cnt
);
  localparam int NSLOT = 2;

  iclass_e         cls_q [NSLOT];
  logic [RW-1:0]   dst_q [NSLOT];
  logic [RW-1:0]   sra_q [NSLOT];
  logic [RW-1:0]   srb_q [NSLOT];
  logic [NSLOT-1:0] v_q;

  iclass_e         in_cls [NSLOT];
  logic [RW-1:0]   in_dst [NSLOT];
  logic [RW-1:0]   in_sra [NSLOT];
  logic [RW-1:0]   in_srb [NSLOT];

  logic [NSLOT-1:0] src_blk;
  logic             pair_ok;
  logic             dep_raw;
  logic             go_old, go_yng;
  logic [1:0]       occ;

  assign in_cls[0] = iclass_e'(old_cls);
  assign in_dst[0] = old_dst;
  assign in_sra[0] = old_sra;
  assign in_srb[0] = old_srb;
  assign in_cls[1] = iclass_e'(yng_cls);
  assign in_dst[1] = yng_dst;
  assign in_sra[1] = yng_sra;
  assign in_srb[1] = yng_srb;

  // per-slot scoreboard check
  for (genvar g = 0; g < NSLOT; g++) begin : g_haz
    dip_src_hazard #(.NREG(NREG), .RW(RW)) u_haz (
      .cls     (cls_q[g]),
      .sra     (sra_q[g]),
      .srb     (srb_q[g]),
      .busy    (load_busy),
      .blocked (src_blk[g])
    );
  end

  dip_pair_rules u_rules (
    .cls_a   (cls_q[0]),
    .cls_b   (cls_q[1]),
    .pair_ok (pair_ok)
  );

  // younger reads what older writes
  always_comb begin
    dep_raw = writes_dst(cls_q[0]) &&
              ((reads_a(cls_q[1]) && (sra_q[1] == dst_q[0])) ||
               (reads_b(cls_q[1]) && (srb_q[1] == dst_q[0])));
  end

  always_comb begin
    go_old     = v_q[0] && !src_blk[0] && !stall;
    go_yng     = go_old && v_q[1] && !src_blk[1] && pair_ok && !dep_raw;
    iss_cnt    = {1'b0, go_old} + {1'b0, go_yng};
    occ        = {1'b0, v_q[0]} + {1'b0, v_q[1]};
    pair_ready = !stall && (iss_cnt == occ);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        cls_q[i] <= CL_NOP;
        dst_q[i] <= '0;
        sra_q[i] <= '0;
        srb_q[i] <= '0;
      end
    end else if (!stall) begin
      if (pair_valid && pair_ready) begin
        v_q <= '1;
        for (int i = 0; i < NSLOT; i++) begin
          cls_q[i] <= in_cls[i];
          dst_q[i] <= in_dst[i];
          sra_q[i] <= in_sra[i];
          srb_q[i] <= in_srb[i];
        end
      end else if (go_old) begin
        if (v_q[1] && !go_yng) begin
          cls_q[0] <= cls_q[1];
          dst_q[0] <= dst_q[1];
          sra_q[0] <= sra_q[1];
          srb_q[0] <= srb_q[1];
          v_q      <= 2'b01;
        end else begin
          v_q <= '0;
        end
      end
    end
  end

  // R4 (also R2, R3, R5): dual issue only for a legal class pair
  assert_pair_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_cnt == 2'd2) |-> pair_ok);

  // R6: nothing leaves while the oldest slot has a busy source
  assert_raw_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_cnt != 2'd0) |-> !src_blk[0]);

  // R7: a blocked oldest slot stops both slots
  assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q[0] && src_blk[0]) |-> (iss_cnt == 2'd0));

  // R9: partial issue leaves one held slot
  assert_hold_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_cnt == 2'd1 && v_q == 2'b11 && !stall) |=> (v_q == 2'b01));

  // R10: stall freezes the slots
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(v_q) && $stable(dst_q[0]) && $stable(sra_q[1])));

  // R12: an accepted pair fills both slots
  assert_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && pair_ready) |=> (v_q == 2'b11));

endmodule

// File: tb/sim_dual_issue_pairer.sv
`timescale 1ns/1ps
module sim_dual_issue_pairer;
  localparam int NREG = 32;
  localparam int RW   = 5;

  localparam logic [2:0] IOP = 3'd0, FOP = 3'd1, ILD = 3'd2, IST = 3'd3,
                         FLD = 3'd4, FST = 3'd5, BR = 3'd6, NOP = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pair_valid = 1'b0;
  logic pair_ready;
  logic [2:0] old_cls = NOP, yng_cls = NOP;
  logic [RW-1:0] old_dst = '0, old_sra = '0, old_srb = '0;
  logic [RW-1:0] yng_dst = '0, yng_sra = '0, yng_srb = '0;
  logic [NREG-1:0] load_busy = '0;
  logic stall = 1'b0;
  logic [1:0] iss_cnt;

  always #2 clk = ~clk;

  dual_issue_pairer #(.NREG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .pair_ready(pair_ready),
    .old_cls(old_cls), .old_dst(old_dst), .old_sra(old_sra), .old_srb(old_srb),
    .yng_cls(yng_cls), .yng_dst(yng_dst), .yng_sra(yng_sra), .yng_srb(yng_srb),
    .load_busy(load_busy), .stall(stall), .iss_cnt(iss_cnt)
  );

  typedef struct {
    int    cnt;
    bit    rdy;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // staged inputs, applied at the next falling edge
  logic            n_valid = 1'b0;
  logic [2:0]      n_oc = NOP, n_yc = NOP;
  logic [RW-1:0]   n_od = '0, n_oa = '0, n_ob = '0;
  logic [RW-1:0]   n_yd = '0, n_ya = '0, n_yb = '0;
  logic [NREG-1:0] n_busy = '0;
  logic            n_stall = 1'b0;

  task automatic tick(input int ecnt, input bit erdy, input string tag);
    exp_t e;
    @(negedge clk);
    pair_valid = n_valid;
    old_cls = n_oc; old_dst = n_od; old_sra = n_oa; old_srb = n_ob;
    yng_cls = n_yc; yng_dst = n_yd; yng_sra = n_ya; yng_srb = n_yb;
    load_busy = n_busy;
    stall = n_stall;
    e.cnt = ecnt; e.rdy = erdy; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic offer(input logic [2:0] oc, input int od, input int oa, input int ob,
                       input logic [2:0] yc, input int yd, input int ya, input int yb);
    n_valid = 1'b1;
    n_oc = oc; n_od = RW'(od); n_oa = RW'(oa); n_ob = RW'(ob);
    n_yc = yc; n_yd = RW'(yd); n_ya = RW'(ya); n_yb = RW'(yb);
  endtask

  // load a pair into empty slots: that cycle issues nothing and is ready
  task automatic load(input logic [2:0] oc, input int od, input int oa, input int ob,
                      input logic [2:0] yc, input int yd, input int ya, input int yb,
                      input string tag);
    offer(oc, od, oa, ob, yc, yd, ya, yb);
    tick(0, 1'b1, tag);
    n_valid = 1'b0;
  endtask

  // monitor: compare away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (int'(iss_cnt) != e.cnt || pair_ready !== e.rdy) begin
          n_fail++;
          $display("FAIL %s: iss_cnt=%0d pair_ready=%0b expected iss_cnt=%0d pair_ready=%0b",
                   e.tag, iss_cnt, pair_ready, e.cnt, e.rdy);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick(0, 1'b1, "R11 empty after reset");
    tick(0, 1'b1, "R11 empty after reset");

    // R2 integer op + float op
    load(IOP, 1, 2, 3, FOP, 4, 5, 6, "R2 load");
    tick(2, 1'b1, "R2 int+fp dual issue");
    tick(0, 1'b1, "R2 drained");

    // R3 same unit
    load(IOP, 1, 2, 3, IOP, 4, 5, 6, "R3 load");
    tick(1, 1'b0, "R3 two int ops, older only");
    tick(1, 1'b1, "R3 held int op leaves");
    load(ILD, 1, 2, 0, FST, 0, 5, 6, "R3 load");
    tick(1, 1'b0, "R3 two memory ops");
    tick(1, 1'b1, "R3 held store leaves");
    load(BR, 0, 2, 0, BR, 0, 3, 0, "R3 load");
    tick(1, 1'b0, "R3 two branches");
    tick(1, 1'b1, "R3 held branch leaves");
    load(NOP, 0, 0, 0, NOP, 0, 0, 0, "R1 load");
    tick(2, 1'b1, "R1 no-ops need no unit");

    // R4 memory with operate
    load(IST, 0, 2, 3, FOP, 4, 5, 6, "R4 load");
    tick(1, 1'b0, "R4 int store + fp op blocked");
    tick(1, 1'b1, "R4 held fp op leaves");
    load(FST, 0, 2, 3, IOP, 4, 5, 6, "R4 load");
    tick(1, 1'b0, "R4 fp store + int op blocked");
    tick(1, 1'b1, "R4 held int op leaves");
    load(FOP, 4, 5, 6, FST, 0, 2, 3, "R4 load");
    tick(2, 1'b1, "R4 fp op + fp store pair");
    load(FLD, 7, 2, 0, IOP, 4, 5, 6, "R4 load");
    tick(2, 1'b1, "R4 fp load + int op pair");

    // R5 branch pairing
    load(BR, 0, 2, 0, IST, 0, 3, 5, "R5 load");
    tick(1, 1'b0, "R5 branch + int store blocked");
    tick(1, 1'b1, "R5 held store leaves");
    load(IST, 0, 3, 5, BR, 0, 2, 0, "R5 load");
    tick(1, 1'b0, "R5 int store + branch blocked");
    tick(1, 1'b1, "R5 held branch leaves");
    load(BR, 0, 2, 0, FST, 0, 3, 5, "R5 load");
    tick(2, 1'b1, "R5 branch + fp store pair");
    load(BR, 0, 2, 0, ILD, 7, 3, 0, "R5 load");
    tick(2, 1'b1, "R5 branch + int load pair");

    // R8 intra-pair dependence
    load(ILD, 7, 2, 0, FOP, 8, 7, 9, "R8 load");
    tick(1, 1'b0, "R8 younger reads load dst");
    tick(1, 1'b1, "R8 dependent leaves next");
    load(ILD, 7, 2, 0, FOP, 8, 9, 10, "R8 load");
    tick(2, 1'b1, "R8 independent pair");
    load(BR, 7, 2, 0, IOP, 8, 7, 9, "R8 load");
    tick(2, 1'b1, "R8 branch writes no register");

    // R6 / R7 scoreboard on the older slot
    n_busy = 32'h1 << 5;
    load(IOP, 1, 5, 3, FOP, 4, 6, 2, "R7 load");
    tick(0, 1'b0, "R7 older busy, none issue");
    tick(0, 1'b0, "R7 older busy, none issue");
    n_busy = '0;
    tick(2, 1'b1, "R6 busy cleared, both issue");
    n_busy = 32'h1 << 9;
    load(ILD, 1, 2, 9, FOP, 4, 5, 6, "R6 load");
    tick(2, 1'b1, "R6 unread source B busy ignored");
    load(IST, 0, 2, 9, IOP, 4, 5, 6, "R6 load");
    tick(0, 1'b0, "R6 store data source busy");
    n_busy = '0;
    tick(2, 1'b1, "R6 store freed");

    // R9 held younger blocks refill
    n_busy = 32'h1 << 9;
    load(IOP, 1, 2, 3, FOP, 4, 9, 6, "R9 load");
    tick(1, 1'b0, "R9 younger busy, older leaves");
    offer(IOP, 10, 11, 12, FOP, 13, 14, 15);
    tick(0, 1'b0, "R9 held slot blocks refill");
    n_busy = '0;
    tick(1, 1'b1, "R9 held leaves, refill same cycle");
    n_valid = 1'b0;
    tick(2, 1'b1, "R9 new pair issues");
    tick(0, 1'b1, "R9 drained");

    // R10 stall
    load(IOP, 1, 2, 3, FOP, 4, 5, 6, "R10 load");
    n_stall = 1'b1;
    offer(BR, 0, 2, 0, BR, 0, 3, 0);
    tick(0, 1'b0, "R10 stall freezes");
    tick(0, 1'b0, "R12 offer ignored under stall");
    n_stall = 1'b0;
    n_valid = 1'b0;
    tick(2, 1'b1, "R10 original pair kept");
    tick(0, 1'b1, "R10 drained");
    n_stall = 1'b1;
    offer(IOP, 1, 2, 3, FOP, 4, 5, 6);
    tick(0, 1'b0, "R10 empty stage stalled");
    n_stall = 1'b0;
    n_valid = 1'b0;
    tick(0, 1'b1, "R12 nothing taken during stall");

    @(negedge clk);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule